// File: doc/BRIEF.md
# Warp Divergence and Reconvergence Stack

This block keeps the branch-divergence stack of a single warp. A launch command seeds the stack with a start PC and the set of lanes that take part. Each later update command brings three things: a mask of lanes that have finished, the next PC of every lane, and the reconvergence PC of the branch just executed. The block then edits the stack so that its top entry names the PC to issue next, the lanes that issue it, the PC at which those lanes rejoin the rest, a call-depth value and a divergence time stamp.

An update runs as a small state machine that visits one lane per cycle. It collects all lanes that share a next PC into one group, sets aside groups that have already reached a reconvergence point, and writes the remaining groups at a write pointer. When the warp splits, the current top entry first becomes the reconvergence entry. If every group is set aside, the stack pops. The states are IDLE (waiting for a command), SCAN (one lane per cycle, highest index first), COMMIT (divergence decision and reconvergence-entry rewrite) and PLACE (group write, then the end-of-update decision). The transitions are IDLE→SCAN on an accepted update, SCAN→SCAN while lanes remain to visit, SCAN→COMMIT after lane 0, COMMIT→PLACE always, PLACE→SCAN while unassigned lanes remain, and PLACE→IDLE when none remain or on overflow. A launch, or an update that finds an empty top mask, is handled in IDLE and does not leave it.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the depth (top index) is 0, every entry has PC and reconvergence PC all-ones, mask 0, call depth 0 and stamp 0, and busy, done and error are low.
- R2: A launch in IDLE clears every entry to the reset values and then loads entry 0 with the given PC, the given mask, call depth 1 and reconvergence PC all-ones. It also clears the error flag. A launch while busy has no effect.
- R3: An update removes lanes marked done. It then scans the remaining lanes from the highest index down. The first lane fixes a group PC (PC 0 means "no group yet"), and every later lane with the same next PC joins that group. Groups are written in the order they form, so the group holding the lowest leading lane ends on top.
- R4: When exactly one group survives and no lanes remain beside it, that group replaces the top entry's PC and mask. The top keeps its reconvergence PC and call depth, and the depth is unchanged.
- R5: On divergence (the first surviving group forms while other lanes remain) and a supplied reconvergence PC that differs from the top's, the top's PC becomes the supplied reconvergence PC. Each surviving group is then pushed above it with call depth 0 and the supplied reconvergence PC.
- R6: On divergence where the supplied reconvergence PC equals the top's, no reconvergence entry is made, and the groups are written starting at the current top.
- R7: A group whose PC equals the top's reconvergence PC is dropped. After divergence, a group whose PC equals the supplied reconvergence PC is also dropped.
- R8: When every group is dropped or every lane is done, the depth falls by one, and the entry below shows at the outputs.
- R9: An update that finds the top mask empty sets the error flag, leaves the stack unchanged and pulses done on the next cycle.
- R10: An update that would pop below depth 0 sets the error flag and leaves the depth at 0. An update that would write past the last entry sets the error flag and leaves the depth unchanged.
- R11: Done pulses for one cycle, exactly 1 + max(G,1)·(LANES+2) clock edges after an accepted update, counting the accepting edge, where G is the number of groups formed. Busy is high in between. While the block is idle and gets no command, the depth and the top outputs hold.
- R12: The error flag stays set through later updates until a launch or a reset.
- R13: A reconvergence entry made by a divergence carries a nonzero stamp (the free-running cycle count). Entries written by launch have stamp 0, and a divergence clears the stamp of the slot just above the reconvergence entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| launch_i | input | 1 | Launch command |
| launch_pc_i | input | PCW | Start PC |
| launch_mask_i | input | LANES | Initial active lanes |
| upd_start_i | input | 1 | Update command |
| upd_done_mask_i | input | LANES | Lanes that have finished |
| upd_next_pc_i | input | LANES·PCW | Next PC per lane, lane i at bits i·PCW upward |
| upd_rpc_i | input | PCW | Reconvergence PC of the branch |
| busy_o | output | 1 | Update in progress |
| done_o | output | 1 | One-cycle update completion pulse |
| err_o | output | 1 | Sticky error flag |
| depth_o | output | log2(2·LANES) | Top index |
| top_pc_o | output | PCW | PC of top entry |
| top_rpc_o | output | PCW | Reconvergence PC of top entry |
| top_mask_o | output | LANES | Lane mask of top entry |
| top_cd_o | output | CDW | Call depth of top entry |
| top_stamp_o | output | STW | Divergence stamp of top entry |

## Verification
A launch is visible on the outputs at the first clock edge after it is sampled. An update on an empty top mask raises done and the error flag one edge after it is accepted. Any other update takes 1 + max(G,1)·(LANES+2) edges to finish, and the bench computes G from its own grouping model before it issues the command. The bench counts edges until done and checks that count against the formula. It compares the top outputs with the model only on idle cycles after completion, because the top may move while the block is busy.

// File: rtl/simt_stk_pkg.sv
package simt_stk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_COMMIT = 2'd2,
        ST_PLACE  = 2'd3
    } stk_state_e;

endpackage

// File: rtl/simt_cyc_ctr.sv
module simt_cyc_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_o <= '0;
        else        count_o <= count_o + W'(1);
    end
endmodule

// File: rtl/simt_lane_pick.sv
module simt_lane_pick #(
    parameter int PCW = 32
) (
    input  logic           active_i,
    input  logic [PCW-1:0] lane_pc_i,
    input  logic [PCW-1:0] grp_pc_i,
    output logic           take_o,
    output logic           opens_o
);
    // PC 0 marks a group that has no leader yet
    always_comb begin
        opens_o = active_i && (grp_pc_i == '0);
        take_o  = opens_o || (active_i && (lane_pc_i == grp_pc_i));
    end
endmodule

// File: rtl/simt_entry_store.sv
module simt_entry_store #(
    parameter int DEPTH = 64,
    parameter int LANES = 32,
    parameter int PCW   = 32,
    parameter int CDW   = 8,
    parameter int STW   = 32,
    parameter int IW    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             wr_en_i,
    input  logic [IW-1:0]    wr_idx_i,
    input  logic [PCW-1:0]   wr_pc_i,
    input  logic [LANES-1:0] wr_mask_i,
    input  logic [PCW-1:0]   wr_rpc_i,
    input  logic             wr_cd_en_i,
    input  logic [CDW-1:0]   wr_cd_i,
    input  logic             div_en_i,
    input  logic [IW-1:0]    div_idx_i,
    input  logic [PCW-1:0]   div_pc_i,
    input  logic [STW-1:0]   div_stamp_i,
    input  logic [IW-1:0]    rd_idx_i,
    output logic [PCW-1:0]   rd_pc_o,
    output logic [LANES-1:0] rd_mask_o,
    output logic [PCW-1:0]   rd_rpc_o,
    output logic [CDW-1:0]   rd_cd_o,
    output logic [STW-1:0]   rd_stamp_o
);
    logic [DEPTH-1:0][PCW-1:0]   pc_v;
    logic [DEPTH-1:0][PCW-1:0]   rpc_v;
    logic [DEPTH-1:0][LANES-1:0] mask_v;
    logic [DEPTH-1:0][CDW-1:0]   cd_v;
    logic [DEPTH-1:0][STW-1:0]   st_v;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [PCW-1:0]   pc_r;
        logic [PCW-1:0]   rpc_r;
        logic [LANES-1:0] m_r;
        logic [CDW-1:0]   cd_r;
        logic [STW-1:0]   st_r;
        logic             hit_wr;
        logic             hit_dv;
        logic             hit_nx;

        assign hit_wr = wr_en_i && (wr_idx_i == IW'(i));
        assign hit_dv = div_en_i && (div_idx_i == IW'(i));
        assign hit_nx = div_en_i && ((int'(div_idx_i) + 1) == i);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pc_r  <= '1;
                rpc_r <= '1;
                m_r   <= '0;
                cd_r  <= '0;
                st_r  <= '0;
            end else if (clr_i) begin
                pc_r  <= hit_wr ? wr_pc_i   : '1;
                rpc_r <= hit_wr ? wr_rpc_i  : '1;
                m_r   <= hit_wr ? wr_mask_i : '0;
                cd_r  <= hit_wr ? wr_cd_i   : '0;
                st_r  <= '0;
            end else begin
                if (hit_dv) begin
                    pc_r <= div_pc_i;
                    st_r <= div_stamp_i;
                end
                if (hit_nx) st_r <= '0;
                if (hit_wr) begin
                    pc_r  <= wr_pc_i;
                    m_r   <= wr_mask_i;
                    rpc_r <= wr_rpc_i;
                    if (wr_cd_en_i) cd_r <= wr_cd_i;
                end
            end
        end

        assign pc_v[i]   = pc_r;
        assign rpc_v[i]  = rpc_r;
        assign mask_v[i] = m_r;
        assign cd_v[i]   = cd_r;
        assign st_v[i]   = st_r;
    end

    always_comb begin
        rd_pc_o    = pc_v[rd_idx_i];
        rd_rpc_o   = rpc_v[rd_idx_i];
        rd_mask_o  = mask_v[rd_idx_i];
        rd_cd_o    = cd_v[rd_idx_i];
        rd_stamp_o = st_v[rd_idx_i];
    end
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
    import simt_stk_pkg::*;
#(
    parameter int LANES = 32,
    parameter int PCW   = 32,
    parameter int CDW   = 8,
    parameter int STW   = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         launch_i,
    input  logic [PCW-1:0]               launch_pc_i,
    input  logic [LANES-1:0]             launch_mask_i,
    input  logic                         upd_start_i,
    input  logic [LANES-1:0]             upd_done_mask_i,
    input  logic [LANES*PCW-1:0]         upd_next_pc_i,
    input  logic [PCW-1:0]               upd_rpc_i,
    output logic                         busy_o,
    output logic                         done_o,
    output logic                         err_o,
    output logic [$clog2(2*LANES)-1:0]   depth_o,
    output logic [PCW-1:0]               top_pc_o,
    output logic [PCW-1:0]               top_rpc_o,
    output logic [LANES-1:0]             top_mask_o,
    output logic [CDW-1:0]               top_cd_o,
    output logic [STW-1:0]               top_stamp_o
);
    localparam int DEPTH = 2 * LANES;
    localparam int IW    = $clog2(DEPTH);
    localparam int PW    = IW + 1;
    localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;

    stk_state_e state_q, state_d;

    logic [IW-1:0]              top_q;
    logic [PW-1:0]              wp_q;
    logic [LW-1:0]              lane_q;
    logic [LANES-1:0]           work_q;
    logic [LANES-1:0]           grp_mask_q;
    logic [PCW-1:0]             grp_pc_q;
    logic [LANES-1:0][PCW-1:0]  npc_q;
    logic [PCW-1:0]             rpc_q;
    logic [PCW-1:0]             top_rpc_q;
    logic                       div_q;
    logic                       err_q;
    logic                       done_q;

    logic [STW-1:0]   cyc;
    logic [PCW-1:0]   rd_pc, rd_rpc;
    logic [LANES-1:0] rd_mask;
    logic [CDW-1:0]   rd_cd;
    logic [STW-1:0]   rd_stamp;

    logic             clr, wr_en, wr_cd_en, div_en;
    logic [IW-1:0]    wr_idx;
    logic [PCW-1:0]   wr_pc, wr_rpc;
    logic [LANES-1:0] wr_mask;
    logic [CDW-1:0]   wr_cd;

    logic take, opens;
    logic grp_live, keep1, fork_now, rewrite, keep2, ovf;
    logic [PW-1:0] nxt_wp;

    simt_cyc_ctr #(.W(STW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .count_o(cyc)
    );

    simt_lane_pick #(.PCW(PCW)) u_pick (
        .active_i (work_q[lane_q]),
        .lane_pc_i(npc_q[lane_q]),
        .grp_pc_i (grp_pc_q),
        .take_o   (take),
        .opens_o  (opens)
    );

    simt_entry_store #(
        .DEPTH(DEPTH), .LANES(LANES), .PCW(PCW), .CDW(CDW), .STW(STW), .IW(IW)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .clr_i(clr),
        .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_pc_i(wr_pc), .wr_mask_i(wr_mask),
        .wr_rpc_i(wr_rpc), .wr_cd_en_i(wr_cd_en), .wr_cd_i(wr_cd),
        .div_en_i(div_en), .div_idx_i(wp_q[IW-1:0]), .div_pc_i(rpc_q), .div_stamp_i(cyc),
        .rd_idx_i(top_q),
        .rd_pc_o(rd_pc), .rd_mask_o(rd_mask), .rd_rpc_o(rd_rpc), .rd_cd_o(rd_cd),
        .rd_stamp_o(rd_stamp)
    );

    // group decisions for the group just scanned
    always_comb begin
        grp_live = |grp_mask_q;
        keep1    = grp_live && (grp_pc_q != top_rpc_q);
        fork_now = keep1 && (|work_q) && !div_q;
        rewrite  = fork_now && (rpc_q != top_rpc_q);
        keep2    = keep1 && !(div_q && (grp_pc_q == rpc_q));
        ovf      = keep2 && (wp_q == PW'(DEPTH));
        nxt_wp   = wp_q + PW'(keep2);
    end

    // stack write controls
    always_comb begin
        clr      = (state_q == ST_IDLE) && launch_i;
        wr_en    = 1'b0;
        wr_idx   = wp_q[IW-1:0];
        wr_pc    = grp_pc_q;
        wr_mask  = grp_mask_q;
        wr_rpc   = div_q ? rpc_q : top_rpc_q;
        wr_cd_en = div_q;
        wr_cd    = '0;
        div_en   = (state_q == ST_COMMIT) && rewrite;
        if (clr) begin
            wr_en    = 1'b1;
            wr_idx   = '0;
            wr_pc    = launch_pc_i;
            wr_mask  = launch_mask_i;
            wr_rpc   = '1;
            wr_cd_en = 1'b1;
            wr_cd    = CDW'(1);
        end else if ((state_q == ST_PLACE) && keep2 && !ovf) begin
            wr_en = 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!launch_i && upd_start_i && (|rd_mask)) state_d = ST_SCAN;
            ST_SCAN:   if (lane_q == '0) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_PLACE;
            ST_PLACE:  state_d = (ovf || !(|work_q)) ? ST_IDLE : ST_SCAN;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q      <= '0;
            wp_q       <= '0;
            lane_q     <= '0;
            work_q     <= '0;
            grp_mask_q <= '0;
            grp_pc_q   <= '0;
            npc_q      <= '0;
            rpc_q      <= '0;
            top_rpc_q  <= '0;
            div_q      <= 1'b0;
            err_q      <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (launch_i) begin
                        top_q <= '0;
                        err_q <= 1'b0;
                    end else if (upd_start_i) begin
                        if (!(|rd_mask)) begin
                            err_q  <= 1'b1;
                            done_q <= 1'b1;
                        end else begin
                            work_q     <= rd_mask & ~upd_done_mask_i;
                            npc_q      <= upd_next_pc_i;
                            rpc_q      <= upd_rpc_i;
                            top_rpc_q  <= rd_rpc;
                            wp_q       <= PW'(top_q);
                            div_q      <= 1'b0;
                            lane_q     <= LW'(LANES - 1);
                            grp_pc_q   <= '0;
                            grp_mask_q <= '0;
                        end
                    end
                end
                ST_SCAN: begin
                    if (take) begin
                        if (opens) grp_pc_q <= npc_q[lane_q];
                        grp_mask_q[lane_q] <= 1'b1;
                        work_q[lane_q]     <= 1'b0;
                    end
                    if (lane_q != '0) lane_q <= lane_q - LW'(1);
                end
                ST_COMMIT: begin
                    if (rewrite)  wp_q  <= wp_q + PW'(1);
                    if (fork_now) div_q <= 1'b1;
                end
                ST_PLACE: begin
                    if (ovf) begin
                        err_q  <= 1'b1;
                        done_q <= 1'b1;
                    end else begin
                        wp_q <= nxt_wp;
                        if (!(|work_q)) begin
                            done_q <= 1'b1;
                            if (nxt_wp == '0) err_q <= 1'b1;
                            else              top_q <= IW'(nxt_wp - PW'(1));
                        end else begin
                            lane_q     <= LW'(LANES - 1);
                            grp_pc_q   <= '0;
                            grp_mask_q <= '0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy_o      = (state_q != ST_IDLE);
        done_o      = done_q;
        err_o       = err_q;
        depth_o     = top_q;
        top_pc_o    = rd_pc;
        top_rpc_o   = rd_rpc;
        top_mask_o  = rd_mask;
        top_cd_o    = rd_cd;
        top_stamp_o = rd_stamp;
    end
endmodule

// File: rtl/simt_reconv_stack_chk.sv
module simt_reconv_stack_chk #(
    parameter int LANES = 32,
    parameter int PCW   = 32,
    parameter int CDW   = 8,
    parameter int STW   = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       launch_i,
    input logic [PCW-1:0]             launch_pc_i,
    input logic [LANES-1:0]           launch_mask_i,
    input logic                       upd_start_i,
    input logic                       busy_o,
    input logic                       done_o,
    input logic                       err_o,
    input logic [$clog2(2*LANES)-1:0] depth_o,
    input logic [PCW-1:0]             top_pc_o,
    input logic [LANES-1:0]           top_mask_o,
    input logic [CDW-1:0]             top_cd_o
);
    // R2
    launch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_i && !busy_o) |=> (depth_o == '0) && (top_pc_o == $past(launch_pc_i))
            && (top_mask_o == $past(launch_mask_i)) && (top_cd_o == CDW'(1)) && !err_o);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !launch_i && !upd_start_i) |=> $stable(depth_o) && $stable(top_pc_o)
            && $stable(top_mask_o));

    // R9
    empty_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !launch_i && upd_start_i && (top_mask_o == '0)) |=> err_o && done_o
            && $stable(depth_o));

    // R12
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !launch_i) |=> err_o);

    // R10
    err_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $stable(depth_o));
endmodule

bind simt_reconv_stack simt_reconv_stack_chk #(
    .LANES(LANES), .PCW(PCW), .CDW(CDW), .STW(STW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .launch_i(launch_i), .launch_pc_i(launch_pc_i),
    .launch_mask_i(launch_mask_i), .upd_start_i(upd_start_i), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .depth_o(depth_o), .top_pc_o(top_pc_o),
    .top_mask_o(top_mask_o), .top_cd_o(top_cd_o)
);

// File: tb/sim_simt_reconv_stack.sv
`timescale 1ns/1ps
module sim_simt_reconv_stack;
    localparam int L  = 8;
    localparam int P  = 16;
    localparam int D  = 2 * L;
    localparam int IW = $clog2(D);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic launch_i = 1'b0;
    logic [P-1:0] launch_pc_i = '0;
    logic [L-1:0] launch_mask_i = '0;
    logic upd_start_i = 1'b0;
    logic [L-1:0] upd_done_mask_i = '0;
    logic [L-1:0][P-1:0] upd_np = '0;
    logic [P-1:0] upd_rpc_i = '0;
    logic busy_o, done_o, err_o;
    logic [IW-1:0] depth_o;
    logic [P-1:0] top_pc_o, top_rpc_o;
    logic [L-1:0] top_mask_o;
    logic [7:0] top_cd_o;
    logic [31:0] top_stamp_o;

    always #2 clk = ~clk;

    simt_reconv_stack #(.LANES(L), .PCW(P), .CDW(8), .STW(32)) u0 (
        .clk(clk), .rst_n(rst_n), .launch_i(launch_i), .launch_pc_i(launch_pc_i),
        .launch_mask_i(launch_mask_i), .upd_start_i(upd_start_i),
        .upd_done_mask_i(upd_done_mask_i), .upd_next_pc_i(upd_np), .upd_rpc_i(upd_rpc_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .depth_o(depth_o),
        .top_pc_o(top_pc_o), .top_rpc_o(top_rpc_o), .top_mask_o(top_mask_o),
        .top_cd_o(top_cd_o), .top_stamp_o(top_stamp_o)
    );

    // behavioural model
    logic [P-1:0] m_pc [D];
    logic [P-1:0] m_rpc [D];
    logic [L-1:0] m_mask [D];
    logic [7:0]   m_cd [D];
    bit           m_st [D];
    int           m_top;
    bit           m_err;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    cmp_en = 1'b0;
    bit    finished = 1'b0;
    string cur_req = "R1";
    int    cyc = 0;

    task automatic chk(input string tag, input string what, input logic [63:0] got,
                       input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic void m_clear();
        for (int i = 0; i < D; i++) begin
            m_pc[i] = '1; m_rpc[i] = '1; m_mask[i] = '0; m_cd[i] = '0; m_st[i] = 1'b0;
        end
        m_top = 0;
    endfunction

    function automatic int m_update(input logic [L-1:0] dn, input logic [L-1:0][P-1:0] np,
                                    input logic [P-1:0] rpc);
        logic [L-1:0] work, gm;
        logic [P-1:0] trpc, grpc;
        int wp, passes;
        bit dv;
        if (m_mask[m_top] == '0) begin
            m_err = 1'b1;
            return 0;
        end
        work = m_mask[m_top] & ~dn;
        trpc = m_rpc[m_top];
        wp = m_top; dv = 1'b0; passes = 0;
        do begin
            grpc = '0; gm = '0;
            for (int i = L - 1; i >= 0; i--) begin
                if (work[i]) begin
                    if (grpc == '0) begin grpc = np[i]; gm[i] = 1'b1; work[i] = 1'b0; end
                    else if (np[i] == grpc) begin gm[i] = 1'b1; work[i] = 1'b0; end
                end
            end
            passes++;
            if (gm == '0) continue;
            if (grpc == trpc) continue;
            if (work != '0 && !dv) begin
                dv = 1'b1;
                if (rpc != trpc) begin
                    m_pc[wp] = rpc; m_st[wp] = 1'b1; wp++;
                    if (wp < D) m_st[wp] = 1'b0;
                end
            end
            if (dv && grpc == rpc) continue;
            if (wp == D) begin m_err = 1'b1; return passes; end
            m_pc[wp] = grpc; m_mask[wp] = gm; m_rpc[wp] = dv ? rpc : trpc;
            if (dv) m_cd[wp] = '0;
            wp++;
        end while (work != '0);
        if (wp == 0) m_err = 1'b1;
        else m_top = wp - 1;
        return passes;
    endfunction

    // compare on every idle clock
    always @(negedge clk) begin
        if (rst_n && cmp_en && !busy_o && !finished) begin
            chk(cur_req, "depth", 64'(depth_o), 64'(m_top));
            chk(cur_req, "top_pc", 64'(top_pc_o), 64'(m_pc[m_top]));
            chk(cur_req, "top_rpc", 64'(top_rpc_o), 64'(m_rpc[m_top]));
            chk(cur_req, "top_mask", 64'(top_mask_o), 64'(m_mask[m_top]));
            chk(cur_req, "top_cd", 64'(top_cd_o), 64'(m_cd[m_top]));
            chk(cur_req, "stamp_set", 64'(top_stamp_o != 0), 64'(m_st[m_top]));
            chk(cur_req, "err", 64'(err_o), 64'(m_err));
        end
    end

    task automatic do_launch(input logic [P-1:0] pc, input logic [L-1:0] mask);
        cmp_en = 1'b0;
        @(negedge clk);
        launch_i = 1'b1; launch_pc_i = pc; launch_mask_i = mask;
        @(negedge clk);
        launch_i = 1'b0;
        m_clear();
        m_pc[0] = pc; m_mask[0] = mask; m_cd[0] = 8'd1; m_err = 1'b0;
        cmp_en = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_update(input logic [L-1:0] dn, input logic [L-1:0][P-1:0] np,
                             input logic [P-1:0] rpc, input bit mid_launch);
        int g, edges, lat;
        cmp_en = 1'b0;
        g = m_update(dn, np, rpc);
        @(negedge clk);
        upd_start_i = 1'b1; upd_done_mask_i = dn; upd_np = np; upd_rpc_i = rpc;
        @(negedge clk);
        upd_start_i = 1'b0;
        edges = 1;
        while (!done_o && edges < 4000) begin
            if (mid_launch && edges == 3) begin
                launch_i = 1'b1; launch_pc_i = 16'h0AAA; launch_mask_i = 8'h01;
            end else begin
                launch_i = 1'b0;
            end
            @(negedge clk);
            edges++;
        end
        launch_i = 1'b0;
        lat = (g == 0) ? 1 : 1 + g * (L + 2);
        chk("R11", "latency", 64'(edges), 64'(lat));
        cmp_en = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [L-1:0][P-1:0] np;
        m_clear(); m_err = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1"; cmp_en = 1'b1;
        chk("R1", "busy", 64'(busy_o), 64'd0);
        chk("R1", "done", 64'(done_o), 64'd0);
        repeat (3) @(negedge clk);

        // R9: update with an empty top mask
        cur_req = "R9";
        for (int i = 0; i < L; i++) np[i] = 16'h0104;
        do_update('0, np, 16'h0200, 1'b0);

        // R2 and R12: launch loads entry 0 and clears the error
        cur_req = "R2";
        do_launch(16'h0100, 8'hFF);

        // R4: uniform branch
        cur_req = "R4";
        do_update('0, np, 16'h0200, 1'b0);

        // R5 and R3: two-way divergence, new reconvergence entry
        cur_req = "R5";
        for (int i = 0; i < L; i++) np[i] = (i >= 4) ? 16'h0110 : 16'h0120;
        do_update('0, np, 16'h0200, 1'b0);

        // R8: top group reaches its reconvergence PC, stack pops
        cur_req = "R8";
        for (int i = 0; i < L; i++) np[i] = 16'h0200;
        do_update('0, np, 16'h0200, 1'b0);

        // R6 and R7: divergence with unchanged reconvergence PC
        cur_req = "R6";
        for (int i = 0; i < L; i++) np[i] = (i == 7 || i == 5) ? 16'h0130 : 16'h0200;
        do_update('0, np, 16'h0200, 1'b0);

        // R3 and R13: done lane removed, pop reveals the stamped entry
        cur_req = "R13";
        for (int i = 0; i < L; i++) np[i] = 16'h0200;
        do_update(8'h80, np, 16'h0200, 1'b0);

        // R10: pop below depth 0
        cur_req = "R10";
        for (int i = 0; i < L; i++) np[i] = 16'hFFFF;
        do_update('0, np, 16'h0300, 1'b0);

        // R12: error persists across a later good update
        cur_req = "R12";
        for (int i = 0; i < L; i++) np[i] = 16'h0300;
        do_update('0, np, 16'h0400, 1'b0);

        // R7: after divergence a group at the new reconvergence PC is dropped
        cur_req = "R7";
        do_launch(16'h0100, 8'hFF);
        for (int i = 0; i < L; i++) np[i] = (i >= 6) ? 16'h0150 : 16'h0300;
        do_update('0, np, 16'h0300, 1'b0);

        // R3: three groups, partial launch mask and a done lane
        cur_req = "R3";
        do_launch(16'h0100, 8'h7E);
        np = '0;
        np[6] = 16'h0400; np[3] = 16'h0400;
        np[5] = 16'h0410; np[2] = 16'h0410;
        np[4] = 16'h0999; np[1] = 16'h0420;
        do_update(8'h10, np, 16'h0500, 1'b0);

        // R2: launch while busy is ignored
        cur_req = "R2";
        do_launch(16'h0100, 8'hFF);
        for (int i = 0; i < L; i++) np[i] = (i % 2 == 0) ? 16'h0600 : 16'h0610;
        do_update('0, np, 16'h0700, 1'b1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired got %0d cycles expected under 100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule